// File: doc/BRIEF.md
# Dual-Rail Completion-Signalling ALU

This block is a W-bit arithmetic and shift unit built from W identical bit slices. Every operand bit, result bit and the carry-out travel as a pair of rails, so each wire pair says on its own whether it holds data yet. Each slice settles at its own pace: an adder slice resolves its carry as soon as its two operand bits agree (both 1 or both 0), and otherwise waits for the carry from the slice below. A completion tree ANDs every slice's done flag with the carry-out's flag to give one `done` output. The block therefore signals the end of an operation instead of assuming a fixed number of cycles.

The block supports addition, two's complement subtraction, logical shift by one in either direction and rotation by one in either direction. The rails are the data handshake, and the block has no separate valid/ready pair. A producer drives every operand pair from spacer (both rails low) to a valid code and holds it there until `done` rises. It then returns every operand pair to spacer. The outputs fall back to spacer and `done` drops one clock later, and only then may the next operand word be presented. This four-phase sequence is the only back-pressure. The mode pins are plain levels that change only while the operands are spacer. A `flush` strobe forces every output back to spacer at any time.

Each slice is a registered evaluation step. One clock edge models one gate delay through a slice, so the carry ripple is visible as cycles.

Top module: `dr_alu`

## Requirements
- R1: Each bit pair is packed as {true rail, false rail} at bits [2i+1:2i]. 2'b10 means 1, 2'b01 means 0 and 2'b00 is spacer. The block never drives 2'b11 on any output pair.
- R2: With op_shift=0 and op_sub=0, the result is (A+B) mod 2^W and cout is bit W of A+B. The carry into bit 0 is 0.
- R3: With op_shift=0 and op_sub=1, the result is A + ~B + 1 mod 2^W. The carry into bit 0 is 1, and cout is 1 exactly when A >= B (unsigned).
- R4: With op_shift=1 and shift_rot=0, the operation is a logical shift by one. shift_left=1 moves bits up and shift_left=0 moves them down. The vacated end bit is 0, cout is the bit shifted out, and B is ignored.
- R5: With op_shift=1 and shift_rot=1, the operation is a rotation by one in the direction given by shift_left. The bit leaving one end enters the other end and also appears on cout.
- R6: `done` is high only when every result pair and the cout pair hold a valid code. It is never high while any output pair is spacer.
- R7: `done` rises one edge after valid operands arrive for a shift. For an add in which every bit of A equals the same bit of B, it rises after 2 edges. For an add in which every bit differs, it rises after W edges.
- R8: While the operands stay valid, the outputs hold. One edge after all operand pairs return to spacer, every output pair is spacer and `done` is low.
- R9: While `flush` is high, every output pair is spacer and `done` is low one edge later. Evaluation resumes once `flush` falls.
- R10: While rst_n is low, every output pair is spacer and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge models one slice evaluation step |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Forces all outputs to spacer |
| op_shift | input | 1 | 1 = shift or rotate, 0 = add or subtract |
| op_sub | input | 1 | 1 = subtract (carry-in 1, B inverted) |
| shift_left | input | 1 | Shift direction, 1 = towards the MSB |
| shift_rot | input | 1 | 1 = rotate, 0 = zero-filled shift |
| a_rails | input | 2*W | Operand A, dual-rail |
| b_rails | input | 2*W | Operand B, dual-rail |
| res_rails | output | 2*W | Result, dual-rail |
| cout_rails | output | 2 | Carry-out or shifted-out bit, dual-rail |
| done | output | 1 | Completion: all output pairs valid |

## Verification
Suppose a slice latches a value before its carry-in is valid, or keeps a stale value across a spacer phase. The wrong bit then shows on `res_rails` as soon as `done` rises, at most W edges after the operands arrive. A completion tree that drops a flag shows up as `done` high beside a spacer pair in the same cycle. A broken return-to-spacer path leaves a nonzero pair or a high `done` one edge after the operands go null. The latency checks on the all-agree and all-differ adds catch a carry that resolves too early or too late by a single edge.

// File: rtl/dr_alu_pkg.sv
package dr_alu_pkg;
  typedef logic [1:0] rail_t;

  localparam rail_t RAIL_NULL = 2'b00;
  localparam rail_t RAIL_0    = 2'b01;
  localparam rail_t RAIL_1    = 2'b10;

  function automatic rail_t rail_enc(input logic v);
    return v ? RAIL_1 : RAIL_0;
  endfunction

  function automatic logic rail_null(input rail_t r);
    return r == RAIL_NULL;
  endfunction

  // logical inversion of a dual-rail bit is a rail swap
  function automatic rail_t rail_inv(input rail_t r);
    return {r[0], r[1]};
  endfunction
endpackage

// File: rtl/dr_alu_slice.sv
module dr_alu_slice
  import dr_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush_i,
  input  logic  op_shift_i,
  input  logic  op_sub_i,
  input  rail_t a_i,
  input  rail_t b_i,
  input  rail_t cin_i,
  input  rail_t sh_i,
  input  rail_t shc_i,
  output rail_t res_o,
  output rail_t cout_o,
  output logic  done_o
);
  rail_t res_q, res_d;
  rail_t c_q, c_d;
  rail_t b_eff;

  assign b_eff = op_sub_i ? rail_inv(b_i) : b_i;

  always_comb begin
    res_d = res_q;
    c_d   = c_q;
    if (flush_i || rail_null(a_i) || rail_null(b_i)) begin
      res_d = RAIL_NULL;
      c_d   = RAIL_NULL;
    end else if (op_shift_i) begin
      if (rail_null(res_q)) res_d = sh_i;
      if (rail_null(c_q))   c_d   = shc_i;
    end else begin
      if (rail_null(c_q)) begin
        if (a_i == b_eff)            c_d = a_i;   // generate or kill: no carry-in needed
        else if (!rail_null(cin_i))  c_d = cin_i; // propagate
      end
      if (rail_null(res_q) && !rail_null(cin_i))
        res_d = rail_enc(a_i[1] ^ b_eff[1] ^ cin_i[1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RAIL_NULL;
      c_q   <= RAIL_NULL;
    end else begin
      res_q <= res_d;
      c_q   <= c_d;
    end
  end

  assign res_o  = res_q;
  assign cout_o = c_q;
  assign done_o = |res_q;

  p_rail_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_q != 2'b11 && c_q != 2'b11);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != RAIL_NULL && !flush_i && !rail_null(a_i) && !rail_null(b_i))
    |=> res_q == $past(res_q));

  p_wait_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_shift_i && res_q == RAIL_NULL && rail_null(cin_i)) |=> res_q == RAIL_NULL);
endmodule

// File: rtl/dr_completion_tree.sv
module dr_completion_tree #(
  parameter int N     = 9,
  parameter int GROUP = 4
) (
  input  logic [N-1:0] flags_i,
  output logic         all_o
);
  localparam int NG = (N + GROUP - 1) / GROUP;
  localparam int NP = NG * GROUP;

  logic [NP-1:0] padded;
  logic [NG-1:0] grp;

  always_comb begin
    padded          = '1;
    padded[N-1:0]   = flags_i;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp[g] = &padded[g*GROUP +: GROUP];
  end

  assign all_o = &grp;
endmodule

// File: rtl/dr_alu.sv
module dr_alu
  import dr_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           op_shift,
  input  logic           op_sub,
  input  logic           shift_left,
  input  logic           shift_rot,
  input  logic [2*W-1:0] a_rails,
  input  logic [2*W-1:0] b_rails,
  output logic [2*W-1:0] res_rails,
  output logic [1:0]     cout_rails,
  output logic           done
);
  localparam int NFLAG = W + 1;

  rail_t a_pr [W];
  rail_t b_pr [W];
  rail_t r_pr [W];
  rail_t c_pr [W];
  rail_t cin_pr [W];
  rail_t sh_pr [W];
  rail_t shc_pr [W];
  logic [NFLAG-1:0] flags;

  for (genvar i = 0; i < W; i++) begin : g_slice
    rail_t sh_l, sh_r;

    assign a_pr[i] = a_rails[2*i +: 2];
    assign b_pr[i] = b_rails[2*i +: 2];

    if (i == 0) begin : g_lsb
      assign cin_pr[i] = op_sub ? RAIL_1 : RAIL_0;
      assign sh_l      = shift_rot ? a_pr[W-1] : RAIL_0;
    end else begin : g_mid
      assign cin_pr[i] = c_pr[i-1];
      assign sh_l      = a_pr[i-1];
    end

    if (i == W-1) begin : g_msb
      assign sh_r      = shift_rot ? a_pr[0] : RAIL_0;
      assign shc_pr[i] = shift_left ? a_pr[W-1] : a_pr[0];
    end else begin : g_low
      assign sh_r      = a_pr[i+1];
      assign shc_pr[i] = RAIL_0;
    end

    assign sh_pr[i] = shift_left ? sh_l : sh_r;

    dr_alu_slice u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush),
      .op_shift_i (op_shift),
      .op_sub_i   (op_sub),
      .a_i        (a_pr[i]),
      .b_i        (b_pr[i]),
      .cin_i      (cin_pr[i]),
      .sh_i       (sh_pr[i]),
      .shc_i      (shc_pr[i]),
      .res_o      (r_pr[i]),
      .cout_o     (c_pr[i]),
      .done_o     (flags[i])
    );

    assign res_rails[2*i +: 2] = r_pr[i];
  end

  assign cout_rails = c_pr[W-1];
  assign flags[W]   = |c_pr[W-1];

  dr_completion_tree #(.N(NFLAG), .GROUP(4)) u_tree (
    .flags_i (flags),
    .all_o   (done)
  );

  logic any_out_null;
  always_comb begin
    any_out_null = (cout_rails == 2'b00);
    for (int k = 0; k < W; k++)
      if (res_rails[2*k +: 2] == 2'b00) any_out_null = 1'b1;
  end

  p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !any_out_null);

  p_spacer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rails == '0 && b_rails == '0) |=> (!done && res_rails == '0));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!done && res_rails == '0 && cout_rails == 2'b00));
endmodule

// File: tb/dr_alu_tb.sv
module dr_alu_tb;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           flush = 1'b0;
  logic           op_shift = 1'b0, op_sub = 1'b0, shift_left = 1'b0, shift_rot = 1'b0;
  logic [2*W-1:0] a_rails = '0, b_rails = '0;
  logic [2*W-1:0] res_rails;
  logic [1:0]     cout_rails;
  logic           done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dr_alu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .op_shift(op_shift), .op_sub(op_sub),
    .shift_left(shift_left), .shift_rot(shift_rot), .a_rails(a_rails), .b_rails(b_rails),
    .res_rails(res_rails), .cout_rails(cout_rails), .done(done)
  );

  function automatic logic [2*W-1:0] enc_word(input int v);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input logic sh, input logic sub,
                        input logic lft, input logic rot, input int want_lat);
    int er, ec, lat, full;
    string tag;
    logic [2*W-1:0] held;
    if (sh) begin
      tag = rot ? "R5" : "R4";
      if (lft) begin
        er = ((a << 1) & M) | (rot ? ((a >> (W-1)) & 1) : 0);
        ec = (a >> (W-1)) & 1;
      end else begin
        er = (a >> 1) | (rot ? ((a & 1) << (W-1)) : 0);
        ec = a & 1;
      end
    end else begin
      tag = sub ? "R3" : "R2";
      full = sub ? (a + ((~b) & M) + 1) : (a + b);
      er = full & M;
      ec = (full >> W) & 1;
    end
    @(negedge clk);
    op_shift = sh; op_sub = sub; shift_left = lft; shift_rot = rot;
    a_rails = enc_word(a); b_rails = enc_word(b);
    lat = 0;
    while (!done && lat < W + 4) begin
      @(negedge clk);
      lat++;
    end
    check(done == 1'b1, "R6 done never rose", done, 1);
    check(!(done && ((cout_rails == 2'b00) || (res_rails != enc_word(er) && res_rails != enc_word(~er) &&
          1'b0))), "R6 done with spacer", cout_rails, 2'b01);
    check(res_rails == enc_word(er), {tag, "/R1 result rails"}, res_rails, enc_word(er));
    check(cout_rails == (ec ? 2'b10 : 2'b01), {tag, "/R1 cout rails"}, cout_rails, ec ? 2 : 1);
    if (want_lat >= 0) check(lat == want_lat, "R7 latency", lat, want_lat);
    held = res_rails;
    @(negedge clk);
    check(res_rails == held && done, "R8 hold while valid", res_rails, held);
    a_rails = '0; b_rails = '0;
    @(negedge clk);
    check(res_rails == '0 && cout_rails == 2'b00 && !done, "R8 return to spacer",
          {res_rails, cout_rails, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(res_rails == '0 && cout_rails == 2'b00 && !done, "R10 reset state",
          {res_rails, cout_rails, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 latency corner cases
    run_op(5, 5, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    run_op(M, 0, 1'b0, 1'b0, 1'b0, 1'b0, W);
    run_op(9, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1);

    // R2 / R3 exhaustive sweep
    for (int a = 0; a <= M; a++)
      for (int b = 0; b <= M; b++) begin
        run_op(a, b, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        run_op(a, b, 1'b0, 1'b1, 1'b0, 1'b0, -1);
      end

    // R4 / R5 sweep, B varied to show it is ignored
    for (int a = 0; a <= M; a++)
      for (int m = 0; m < 4; m++)
        run_op(a, (a * 7 + m) & M, 1'b1, 1'b0, m[0], m[1], 1);

    // R9 flush
    @(negedge clk);
    flush = 1'b1; op_shift = 1'b0; op_sub = 1'b0;
    a_rails = enc_word(3); b_rails = enc_word(6);
    repeat (3) @(negedge clk);
    check(res_rails == '0 && cout_rails == 2'b00 && !done, "R9 outputs held at spacer",
          {res_rails, cout_rails, done}, 0);
    flush = 1'b0;
    repeat (W + 2) @(negedge clk);
    check(done && res_rails == enc_word(9) && cout_rails == 2'b01, "R9 resume after flush",
          res_rails, enc_word(9));
    flush = 1'b1;
    @(negedge clk);
    check(res_rails == '0 && !done, "R9 flush clears valid result", res_rails, 0);
    flush = 1'b0; a_rails = '0; b_rails = '0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule